// File: doc/BRIEF.md
# Request Byte-Enable Legality Checker

This block inspects the two byte-enable fields of a memory request header, one covering the first DW of the transfer and one covering the last DW, and decides whether they are legal for the request's DW length and direction. A request is offered with a valid strobe. On the next cycle the block gives a registered verdict: a legal flag, a small error code naming the rule that failed, and two flags for the special empty single-DW cases. An empty single-DW write is a no-op. An empty single-DW read acts as an ordering flush.

The rules depend on the length. A single-DW request carries all of its enables in the first field, and its last field has to be empty. It may use any pattern, including gapped ones and the empty pattern. A two-DW request needs both fields non-empty but tolerates gaps in either. A request of three DWs or more must have no hole in its payload. Its first-DW enables therefore form one run that ends at the top byte, and its last-DW enables form one run that starts at byte 0. A length field of zero stands for the maximum length and falls under the long rules. The block is intended to sit in a receive path right after header extraction, where it feeds a malformed-request handler.

Top module: `be_rule_check`

## Requirements
- R1: The outputs are registered. `out_valid` rises exactly one clock after a cycle with `req_valid` high. In a cycle after `req_valid` was low, `out_valid`, `out_legal`, `out_noop`, `out_flush` and `out_err` are all 0. Reset clears all of them.
- R2: For length 1, a non-zero last-DW enable gives error code 1.
- R3: For any length other than 1, a first-DW enable of 0000b gives error code 2.
- R4: For any length other than 1, a last-DW enable of 0000b gives error code 3.
- R5: For a long request (length field 0, meaning 1024 DW, or length 3 or more), the first-DW enable must be 1000b, 1100b, 1110b or 1111b. Any other non-zero value gives error code 4. Bit i of an enable selects byte i of its DW.
- R6: For a long request, the last-DW enable must be 0001b, 0011b, 0111b or 1111b. Any other non-zero value gives error code 5.
- R7: With length 1 and last-DW enable 0000b, every first-DW pattern is legal, including gapped ones such as 1010b. With length 2, any pair of non-zero patterns is legal.
- R8: A write (`req_is_write`=1) of length 1 with both enables 0000b is legal, sets `out_noop` and leaves `out_flush` low.
- R9: A read (`req_is_write`=0) of length 1 with both enables 0000b is legal, sets `out_flush` and leaves `out_noop` low.
- R10: When several rules fail, the smallest error code is reported. The order is 1, 2, 3, 4, 5.
- R11: For a valid result, `out_legal` is 1 exactly when `out_err` is 0. `out_noop` and `out_flush` are never high on an illegal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request fields are valid this cycle |
| req_is_write | input | 1 | 1 = write request, 0 = read request |
| req_len | input | 10 | DW length field, 0 encodes 1024 |
| req_first_be | input | 4 | First-DW byte enables |
| req_last_be | input | 4 | Last-DW byte enables |
| out_valid | output | 1 | Verdict valid |
| out_legal | output | 1 | Request enables are legal |
| out_err | output | 3 | Failed rule code, 0 when legal |
| out_noop | output | 1 | Legal empty single-DW write |
| out_flush | output | 1 | Legal empty single-DW read |

## Verification
The stimulus mixes seeded random traffic with directed cases. The random lengths cluster on 0, 1, 2 and 3, the values where the rule set changes, and the enable nibbles are drawn uniformly, so anchored runs, floating runs, gapped patterns and empty fields all occur at every length class. The directed cases are chosen to pull apart behaviours a faulty design could merge. Gapped patterns are sent at length 2 and at length 3 to tell the tolerant class from the strict one. Floating runs such as 0110b separate "contiguous" from "anchored to the correct end". Empty reads are compared with empty writes to tell flush apart from no-op. Inputs that break several rules at once expose a wrong priority order, and length 0 confirms that it is treated as a long request.

// File: rtl/be_rule_check.sv
module be_rule_check #(
  parameter int LEN_W = 10,
  parameter int BE_W  = 4,
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [BE_W-1:0]  req_first_be,
  input  logic [BE_W-1:0]  req_last_be,
  output logic             out_valid,
  output logic             out_legal,
  output logic [ERR_W-1:0] out_err,
  output logic             out_noop,
  output logic             out_flush
);

  localparam logic [ERR_W-1:0] E_NONE      = ERR_W'(0);
  localparam logic [ERR_W-1:0] E_SGL_LAST  = ERR_W'(1);
  localparam logic [ERR_W-1:0] E_FIRST_0   = ERR_W'(2);
  localparam logic [ERR_W-1:0] E_LAST_0    = ERR_W'(3);
  localparam logic [ERR_W-1:0] E_FIRST_GAP = ERR_W'(4);
  localparam logic [ERR_W-1:0] E_LAST_GAP  = ERR_W'(5);

  wire is_one  = (req_len == LEN_W'(1));
  wire is_two  = (req_len == LEN_W'(2));
  wire is_long = !is_one && !is_two;

  wire first_zero = (req_first_be == '0);
  wire last_zero  = (req_last_be  == '0);

  wire [BE_W-1:0] first_inv = ~req_first_be;
  wire head_run_ok = ((first_inv & (first_inv + BE_W'(1))) == '0);
  wire tail_run_ok = ((req_last_be & (req_last_be + BE_W'(1))) == '0);

  logic [ERR_W-1:0] err_c;
  always_comb begin
    err_c = E_NONE;
    if (is_one) begin
      if (!last_zero) err_c = E_SGL_LAST;
    end else if (first_zero)                err_c = E_FIRST_0;
    else if (last_zero)                     err_c = E_LAST_0;
    else if (is_long && !head_run_ok)       err_c = E_FIRST_GAP;
    else if (is_long && !tail_run_ok)       err_c = E_LAST_GAP;
  end

  wire legal_c = (err_c == E_NONE);
  wire empty_1 = is_one && first_zero && legal_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_legal <= 1'b0;
      out_err   <= E_NONE;
      out_noop  <= 1'b0;
      out_flush <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_legal <= req_valid && legal_c;
      out_err   <= req_valid ? err_c : E_NONE;
      out_noop  <= req_valid && empty_1 && req_is_write;
      out_flush <= req_valid && empty_1 && !req_is_write;
    end
  end

endmodule

// File: rtl/be_rule_check_sva.sv
module be_rule_check_sva #(
  parameter int LEN_W = 10,
  parameter int BE_W  = 4,
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_is_write,
  input logic [LEN_W-1:0] req_len,
  input logic [BE_W-1:0]  req_first_be,
  input logic [BE_W-1:0]  req_last_be,
  input logic             out_valid,
  input logic             out_legal,
  input logic [ERR_W-1:0] out_err,
  input logic             out_noop,
  input logic             out_flush
);

  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_legal && !out_noop && !out_flush && out_err == '0));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_single_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == LEN_W'(1) && req_last_be != '0) |=> (out_err == ERR_W'(1) && !out_legal));

  assert_first_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len != LEN_W'(1) && req_first_be == '0) |=> (out_err == ERR_W'(2)));

  assert_single_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == LEN_W'(1) && req_last_be == '0) |=> out_legal);

  assert_two_gaps_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == LEN_W'(2) && req_first_be != '0 && req_last_be != '0) |=> out_legal);

  assert_empty_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_write && req_len == LEN_W'(1) && req_first_be == '0 && req_last_be == '0)
      |=> (out_noop && !out_flush));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_write && req_len == LEN_W'(1) && req_first_be == '0 && req_last_be == '0)
      |=> (out_flush && !out_noop));

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_noop, out_flush}) && ((out_noop || out_flush) -> out_legal));

  assert_legal_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_legal == (out_err == '0)));

endmodule

bind be_rule_check be_rule_check_sva #(.LEN_W(LEN_W), .BE_W(BE_W), .ERR_W(ERR_W)) u_sva (.*);

// File: tb/be_rule_check_bench.sv
`timescale 1ns/1ps
module be_rule_check_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_is_write = 1'b0;
  logic [9:0] req_len = '0;
  logic [3:0] req_first_be = '0;
  logic [3:0] req_last_be = '0;
  logic       out_valid, out_legal, out_noop, out_flush;
  logic [2:0] out_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  be_rule_check u_be_rule_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_write(req_is_write),
    .req_len(req_len), .req_first_be(req_first_be), .req_last_be(req_last_be),
    .out_valid(out_valid), .out_legal(out_legal), .out_err(out_err),
    .out_noop(out_noop), .out_flush(out_flush));

  function automatic bit head_ok(input logic [3:0] b);
    return (b == 4'b1000 || b == 4'b1100 || b == 4'b1110 || b == 4'b1111);
  endfunction

  function automatic bit tail_ok(input logic [3:0] b);
    return (b == 4'b0001 || b == 4'b0011 || b == 4'b0111 || b == 4'b1111);
  endfunction

  function automatic logic [2:0] exp_err(input logic [9:0] len, input logic [3:0] fb, input logic [3:0] lb);
    if (len == 10'd1) return (lb != 0) ? 3'd1 : 3'd0;
    if (fb == 0) return 3'd2;
    if (lb == 0) return 3'd3;
    if (len == 10'd2) return 3'd0;
    if (!head_ok(fb)) return 3'd4;
    if (!tail_ok(lb)) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (len=%0d wr=%0b fbe=%b lbe=%b)",
               req, act, exp, req_len, req_is_write, req_first_be, req_last_be);
    end
  endtask

  task automatic send(input string req, input bit wr, input logic [9:0] len,
                      input logic [3:0] fb, input logic [3:0] lb);
    logic [2:0] e;
    bit lg;
    e  = exp_err(len, fb, lb);
    lg = (e == 3'd0);
    req_valid = 1'b1; req_is_write = wr; req_len = len; req_first_be = fb; req_last_be = lb;
    @(negedge clk);
    check({req, " err"}, {5'd0, out_err}, {5'd0, e});
    check({req, " legal/valid R11 R1"}, {6'd0, out_legal, out_valid}, {6'd0, lg, 1'b1});
    check({req, " noop R8"}, {7'd0, out_noop}, {7'd0, lg && len == 1 && fb == 0 && wr});
    check({req, " flush R9"}, {7'd0, out_flush}, {7'd0, lg && len == 1 && fb == 0 && !wr});
  endtask

  task automatic idle();
    req_valid = 1'b0; req_is_write = 1'b1; req_len = 10'd1; req_first_be = 4'hF; req_last_be = 4'hF;
    @(negedge clk);
    check("R1 idle clears", {out_valid, out_legal, out_noop, out_flush, 1'b0, out_err}, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] lens [5];
    lens = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd4};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, out_legal, out_noop, out_flush, 1'b0, out_err}, 8'h00);
    rst_n = 1'b1;

    send("R2 single last set", 1, 10'd1, 4'b0001, 4'b0100);
    send("R10 single last beats empty", 0, 10'd1, 4'b0000, 4'b1000);
    send("R3 first zero len2", 1, 10'd2, 4'b0000, 4'b0001);
    send("R10 first zero beats last zero", 0, 10'd5, 4'b0000, 4'b0000);
    send("R4 last zero len3", 1, 10'd3, 4'b1111, 4'b0000);
    send("R5 floating head", 1, 10'd3, 4'b0110, 4'b0001);
    send("R5 gapped head len0", 0, 10'd0, 4'b1010, 4'b1111);
    send("R10 head gap beats tail gap", 1, 10'd8, 4'b0101, 4'b1010);
    send("R6 floating tail", 1, 10'd4, 4'b1000, 4'b0110);
    send("R6 tail top only", 0, 10'd0, 4'b1100, 4'b1000);
    send("R5 R6 anchored ok", 1, 10'd1023, 4'b1110, 4'b0011);
    send("R7 single gapped", 1, 10'd1, 4'b1010, 4'b0000);
    send("R7 two gapped", 0, 10'd2, 4'b0101, 4'b1001);
    send("R8 empty write", 1, 10'd1, 4'b0000, 4'b0000);
    send("R9 empty read", 0, 10'd1, 4'b0000, 4'b0000);
    idle();
    send("R1 after idle", 1, 10'd3, 4'b1000, 4'b0001);

    for (int i = 0; i < 600; i++) begin
      logic [9:0] l;
      l = ($urandom % 4 != 0) ? lens[$urandom % 5] : 10'($urandom);
      if ($urandom % 10 == 0) idle();
      else send("R10 random", 1'($urandom), l, 4'($urandom), 4'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule